// File: doc/BRIEF.md
# Double-Buffered Electrode Phase Array

This block holds a two-phase drive setting for every cell of a rows-by-columns electrode grid (32 x 32 by default) and produces one digital drive bit per cell. Each cell keeps two bits of storage. The first is a hidden next-state bit. The second is a present-state bit, which selects whether the cell output follows the low-rate reference square wave or its inverse. A host uses a bit-serial frame to choose one cell and the value for it. The host then writes that cell's next-state bit. After it has written every cell it wants to change, a single commit strobe moves all next-state bits into the present stage in the same cycle. The outputs of all changed cells therefore move together.

The last column has extra behaviour. Each cell there is paired with an injection bit that is written in the same step as the cell's phase bit, from a separate input, and committed by the same strobe. While a committed injection bit is set, the paired cell's drive is held at a constant low level, and the row's injection flag is raised. An active-low asynchronous clear puts every stage into the 180-degree state and removes every injection override.

The block runs on one system clock, and all control inputs are sampled on its rising edge. Serial bits are accepted whenever `shift_en` is high. There is no back-pressure, so the host must simply hold each bit for one cycle.

Top module: `ep_phase_array`

## Requirements
- R1: Each cycle in which `shift_en` is high shifts `ser_data` into an 11-bit frame. The first 5 bits are the column address, most significant bit first. The next 5 bits are the row address, most significant bit first. The final bit is the phase value (1 means 0 degrees, 0 means 180 degrees).
- R2: Address and phase reach the cells only at a clock edge where `load` is high and was also high at the previous edge. When `wr_n` is low while `load` is low, no cell changes.
- R3: A write takes place at an edge with `wr_n` low and the path open. It updates only the addressed cell's next-state bit, and at most one cell changes per edge.
- R4: Writing next-state bits never changes any drive output or injection flag.
- R5: An edge at which `commit_n` is low after being high at the previous edge copies every next-state bit into its present stage at that edge.
- R6: `drive[row*COLS+col]` equals `ref_wave` when the present bit is 1 and `~ref_wave` when it is 0. It follows `ref_wave` combinationally.
- R7: While `clr_n` is low, every present, next and injection bit is 0, so every drive equals `~ref_wave` and every injection flag is 0. The clear is asynchronous.
- R8: A write to a cell in the last column also stores `inj_bit` into that row's injection next-state bit, which is committed by the R5 strobe. A write to any other column leaves injection state alone.
- R9: While `inj_force[row]` is 1, the last-column drive of that row is 0 whatever the phase bit and `ref_wave` are.
- R10: The frame used for writes is the register content at the edge where `load` is first seen high. Shifting while `load` stays high does not alter the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous active-low clear |
| shift_en | input | 1 | Shift one serial bit this cycle |
| ser_data | input | 1 | Serial frame bit |
| load | input | 1 | Open the address and phase path |
| wr_n | input | 1 | Active-low next-state write |
| commit_n | input | 1 | Commit strobe, acts on its falling edge |
| ref_wave | input | 1 | Low-rate reference square wave |
| inj_bit | input | 1 | Injection value for last-column writes |
| drive | output | ROWS*COLS | Per-cell drive bit, index row*COLS+col |
| inj_force | output | ROWS | Committed injection override per row |

## Verification
The hardest situation to reach is one where the hidden next-state stage differs from the present stage while the outputs still show the old pattern. The bench builds up several pending writes, some of them in the last column with injection set. It checks that nothing visible moves until the single commit edge, and then that all of the pending cells change together. A second hard case is shifting a new frame while `load` is still held high. The bench does this and then writes, which shows that the write lands on the snapshot address and not on the newer frame.

// File: rtl/ep_pkg.sv
package ep_pkg;
  localparam int unsigned DEF_ROWS = 32;
  localparam int unsigned DEF_COLS = 32;

  typedef enum logic {
    PH_180 = 1'b0,
    PH_0   = 1'b1
  } phase_e;
endpackage

// File: rtl/ep_frame.sv
module ep_frame #(
  parameter int unsigned ROWS = ep_pkg::DEF_ROWS,
  parameter int unsigned COLS = ep_pkg::DEF_COLS
) (
  input  logic            clk,
  input  logic            clr_n,
  input  logic            shift_en,
  input  logic            ser_data,
  input  logic            load,
  output logic [ROWS-1:0] row_hot,
  output logic [COLS-1:0] col_hot,
  output logic            phase_bit
);
  localparam int unsigned RAW = $clog2(ROWS);
  localparam int unsigned CAW = $clog2(COLS);
  localparam int unsigned FW  = CAW + RAW + 1;

  logic [FW-1:0]  sr_q;
  logic [FW-1:0]  snap_q;
  logic           load_q;
  logic           gate;
  logic [RAW-1:0] row_addr;
  logic [CAW-1:0] col_addr;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sr_q   <= '0;
      snap_q <= '0;
      load_q <= 1'b0;
    end else begin
      if (shift_en) sr_q <= {sr_q[FW-2:0], ser_data};
      if (load && !load_q) snap_q <= sr_q;
      load_q <= load;
    end
  end

  assign gate      = load & load_q;
  assign col_addr  = snap_q[FW-1 -: CAW];
  assign row_addr  = snap_q[RAW:1];
  assign phase_bit = gate & snap_q[0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_hot[r] = gate && (row_addr == RAW'(r));
  end
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_hot[c] = gate && (col_addr == CAW'(c));
  end

  // Frame is frozen at the first edge with load high (R10)
  assert_snapshot_R10: assert property (@(posedge clk) disable iff (!clr_n)
    (load && !load_q) |=> (snap_q == $past(sr_q)));

  // Shifting under an open path leaves the target alone (R10)
  assert_hold_snapshot_R10: assert property (@(posedge clk) disable iff (!clr_n)
    (load && load_q) |=> $stable(snap_q));
endmodule

// File: rtl/ep_cells.sv
module ep_cells #(
  parameter int unsigned ROWS = ep_pkg::DEF_ROWS,
  parameter int unsigned COLS = ep_pkg::DEF_COLS
) (
  input  logic                 clk,
  input  logic                 clr_n,
  input  logic [ROWS-1:0]      row_hot,
  input  logic [COLS-1:0]      col_hot,
  input  logic                 phase_bit,
  input  logic                 inj_bit,
  input  logic                 wr_n,
  input  logic                 commit_n,
  output logic [ROWS*COLS-1:0] present,
  output logic [ROWS-1:0]      inj_present
);
  localparam int unsigned NCELL = ROWS * COLS;
  localparam int unsigned LASTC = COLS - 1;

  logic [NCELL-1:0] next_q;
  logic [NCELL-1:0] pres_q;
  logic [ROWS-1:0]  inj_next_q;
  logic [ROWS-1:0]  inj_pres_q;
  logic             commit_q;
  logic             commit_fall;

  assign commit_fall = commit_q & ~commit_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      next_q     <= '0;
      pres_q     <= '0;
      inj_next_q <= '0;
      inj_pres_q <= '0;
      commit_q   <= 1'b1;
    end else begin
      commit_q <= commit_n;
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (row_hot[r] && col_hot[c] && !wr_n) next_q[r*COLS+c] <= phase_bit;
        end
        if (row_hot[r] && col_hot[LASTC] && !wr_n) inj_next_q[r] <= inj_bit;
      end
      if (commit_fall) begin
        pres_q     <= next_q;
        inj_pres_q <= inj_next_q;
      end
    end
  end

  assign present     = pres_q;
  assign inj_present = inj_pres_q;

  assert_single_write_R3: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> ($countones(next_q ^ $past(next_q)) <= 1));

  assert_write_hidden_R4: assert property (@(posedge clk) disable iff (!clr_n)
    !commit_fall |=> ($stable(pres_q) && $stable(inj_pres_q)));

  assert_commit_copy_R5: assert property (@(posedge clk) disable iff (!clr_n)
    commit_fall |=> (pres_q == $past(next_q)));

  assert_inj_commit_R8: assert property (@(posedge clk) disable iff (!clr_n)
    commit_fall |=> (inj_pres_q == $past(inj_next_q)));
endmodule

// File: rtl/ep_drive.sv
module ep_drive #(
  parameter int unsigned ROWS = ep_pkg::DEF_ROWS,
  parameter int unsigned COLS = ep_pkg::DEF_COLS
) (
  input  logic [ROWS*COLS-1:0] present,
  input  logic [ROWS-1:0]      inj_present,
  input  logic                 ref_wave,
  output logic [ROWS*COLS-1:0] drive
);
  import ep_pkg::*;

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      phase_e ph;
      logic   wave;
      assign ph   = phase_e'(present[r*COLS+c]);
      assign wave = (ph == PH_0) ? ref_wave : ~ref_wave;
      if (c == COLS - 1) begin : g_edge
        assign drive[r*COLS+c] = inj_present[r] ? 1'b0 : wave;
      end else begin : g_plain
        assign drive[r*COLS+c] = wave;
      end
    end
  end
endmodule

// File: rtl/ep_phase_array.sv
module ep_phase_array #(
  parameter int unsigned ROWS = ep_pkg::DEF_ROWS,
  parameter int unsigned COLS = ep_pkg::DEF_COLS
) (
  input  logic                 clk,
  input  logic                 clr_n,
  input  logic                 shift_en,
  input  logic                 ser_data,
  input  logic                 load,
  input  logic                 wr_n,
  input  logic                 commit_n,
  input  logic                 ref_wave,
  input  logic                 inj_bit,
  output logic [ROWS*COLS-1:0] drive,
  output logic [ROWS-1:0]      inj_force
);
  logic [ROWS-1:0]      row_hot;
  logic [COLS-1:0]      col_hot;
  logic                 phase_bit;
  logic [ROWS*COLS-1:0] present;

  ep_frame #(.ROWS(ROWS), .COLS(COLS)) u_frame (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .ser_data(ser_data),
    .load(load), .row_hot(row_hot), .col_hot(col_hot), .phase_bit(phase_bit)
  );

  ep_cells #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk(clk), .clr_n(clr_n), .row_hot(row_hot), .col_hot(col_hot),
    .phase_bit(phase_bit), .inj_bit(inj_bit), .wr_n(wr_n), .commit_n(commit_n),
    .present(present), .inj_present(inj_force)
  );

  ep_drive #(.ROWS(ROWS), .COLS(COLS)) u_drive (
    .present(present), .inj_present(inj_force), .ref_wave(ref_wave), .drive(drive)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    assert_inj_ground_R9: assert property (@(posedge clk) disable iff (!clr_n)
      inj_force[r] |-> (drive[r*COLS+COLS-1] == 1'b0));
  end
endmodule

// File: tb/test_ep_phase_array.sv
`timescale 1ns/1ps
module test_ep_phase_array;
  localparam int ROWS = 32;
  localparam int COLS = 32;
  localparam int N    = ROWS * COLS;

  logic clk = 1'b0;
  logic clr_n = 1'b0, shift_en = 1'b0, ser_data = 1'b0, load = 1'b0;
  logic wr_n = 1'b1, commit_n = 1'b1, ref_wave = 1'b1, inj_bit = 1'b0;
  logic [N-1:0]    drive;
  logic [ROWS-1:0] inj_force;

  always #2 clk = ~clk;

  ep_phase_array #(.ROWS(ROWS), .COLS(COLS)) i_ep_phase_array (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .ser_data(ser_data),
    .load(load), .wr_n(wr_n), .commit_n(commit_n), .ref_wave(ref_wave),
    .inj_bit(inj_bit), .drive(drive), .inj_force(inj_force)
  );

  // Reference model of the requirements
  logic [N-1:0]    m_next = '0, m_pres = '0;
  logic [ROWS-1:0] m_inj_n = '0, m_inj_p = '0;

  logic [N-1:0]    q_drv[$];
  logic [ROWS-1:0] q_inj[$];
  string           q_tag[$];
  int checks = 0, failures = 0;
  bit done = 0;

  function automatic logic [N-1:0] exp_drive();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      if ((i % COLS) == COLS - 1 && m_inj_p[i / COLS]) v[i] = 1'b0;
      else v[i] = m_pres[i] ? ref_wave : ~ref_wave;
    end
    return v;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_now(input string tag);
    q_drv.push_back(exp_drive());
    q_inj.push_back(m_inj_p);
    q_tag.push_back(tag);
    tick();
  endtask

  // Monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      logic [N-1:0]    ed;
      logic [ROWS-1:0] ej;
      string           t;
      ed = q_drv.pop_front();
      ej = q_inj.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (drive !== ed || inj_force !== ej) begin
        failures++;
        $display("FAIL %s drive=%h inj=%h expected drive=%h inj=%h", t, drive, inj_force, ed, ej);
      end
    end
  end

  task automatic send_frame(input int col, input int row, input logic ph);
    logic [10:0] f;
    f = {col[4:0], row[4:0], ph};
    for (int i = 10; i >= 0; i--) begin
      shift_en = 1'b1; ser_data = f[i];
      tick();
    end
    shift_en = 1'b0;
  endtask

  task automatic write_cell(input int col, input int row, input logic ph, input logic injv);
    send_frame(col, row, ph);
    inj_bit = injv;
    load = 1'b1; tick();
    wr_n = 1'b0; tick();
    wr_n = 1'b1; load = 1'b0; tick();
    m_next[row*COLS+col] = ph;
    if (col == COLS - 1) m_inj_n[row] = injv;
  endtask

  task automatic commit();
    commit_n = 1'b0; tick();
    commit_n = 1'b1;
    m_pres = m_next; m_inj_p = m_inj_n;
  endtask

  initial begin
    tick(); tick();
    expect_now("R7 reset state ref=1");
    ref_wave = 1'b0;
    expect_now("R7 R6 reset state ref=0");
    clr_n = 1'b1; tick();

    // Several pending writes, outputs must not move (R1 R3 R4)
    write_cell(3, 5, 1'b1, 1'b0);
    expect_now("R4 after first write");
    write_cell(5, 3, 1'b1, 1'b0);
    write_cell(31, 0, 1'b1, 1'b0);
    write_cell(0, 31, 1'b1, 1'b0);
    write_cell(17, 10, 1'b1, 1'b0);
    expect_now("R4 after several writes");
    commit();
    expect_now("R5 R1 R3 commit applies all pending cells");
    ref_wave = 1'b1;
    expect_now("R6 phase mapping ref=1");

    // Overwrite one cell back to 180 degrees (R3)
    write_cell(5, 3, 1'b0, 1'b0);
    commit();
    expect_now("R3 single cell overwrite");

    // Write with load low is ignored (R2)
    send_frame(20, 20, 1'b1);
    wr_n = 1'b0; tick(); wr_n = 1'b1; tick();
    commit();
    expect_now("R2 write without load ignored");

    // Shift a new frame while load is held (R10)
    send_frame(8, 8, 1'b1);
    load = 1'b1; tick();
    send_frame(9, 9, 1'b1);
    wr_n = 1'b0; tick();
    wr_n = 1'b1; load = 1'b0; tick();
    m_next[8*COLS+8] = 1'b1;
    commit();
    expect_now("R10 snapshot address used");

    // Injection override (R8 R9)
    write_cell(31, 7, 1'b1, 1'b1);
    write_cell(30, 4, 1'b1, 1'b1);
    expect_now("R4 injection write hidden");
    commit();
    expect_now("R8 R9 injection committed ref=1");
    ref_wave = 1'b0;
    expect_now("R9 injection holds low ref=0");
    write_cell(31, 7, 1'b1, 1'b0);
    commit();
    expect_now("R8 injection released");

    // Asynchronous clear (R7)
    clr_n = 1'b0;
    m_next = '0; m_pres = '0; m_inj_n = '0; m_inj_p = '0;
    expect_now("R7 async clear");
    clr_n = 1'b1; tick();
    commit();
    expect_now("R7 next stage cleared too");

    tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule